// File: doc/BRIEF.md
# Receive Byte FIFO with Packet-End Tags

This block buffers received bytes between a serial packet receiver and a host that drains them. It holds up to 32 entries. Each entry is one data byte plus a one-bit tag that marks the final byte of a packet. The receiver side pushes a byte and its tag with a write strobe. The host side pops with a read strobe and gets the byte and its tag on the following cycle.

Four single-cycle event outputs tell the host what is happening:
- **Packet-end ahead:** a tagged byte has just become the next byte to be read, so the host learns of a packet end before it pops that byte.
- **High fill:** the fill level has just crossed above half the depth.
- **Overflow:** a byte arrived while all entries were occupied. That byte is thrown away and the stored contents are kept.
- **Empty read:** the host popped with nothing stored. It gets a zero byte with the tag clear, and the packet-end event fires as well.

Top module: `rx_pkt_fifo`

## Requirements
- R1: The FIFO accepts 32 writes from empty without an overflow event; the 33rd write with no read in between raises one.
- R2: Bytes and their tags come out in write order; `rd_data`/`rd_tag` show the popped entry in the cycle after the clock edge that sampled `rd_en`, and hold their value while `rd_en` is low.
- R3: A write while 32 entries are stored pulses `evt_ovf` for one cycle after that edge, and the byte is dropped. The stored bytes and their order are unchanged.
- R4: `evt_above` pulses for one cycle when the fill level goes from 16 to 17. It does not fire again until the level has dropped to 16 or below and then risen once more.
- R5: `evt_last` pulses for one cycle whenever a tagged entry becomes the head. This happens either when the tagged entry is written into an empty FIFO or when a read exposes it. Two tagged entries in a row give two pulses.
- R6: A read while empty pulses `evt_rd_empty` and `evt_last` for one cycle, returns `rd_data` = 0 with `rd_tag` = 0, and leaves the stored contents and pointers untouched.
- R7: After reset, all event outputs are low, `rd_data` and `rd_tag` are zero, and the FIFO is empty.
- R8: A read and a write in the same cycle while full serve the read and drop the write, with an overflow event, leaving 31 entries.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Write strobe from the receiver |
| wr_data | input | 8 | Byte to store |
| wr_tag | input | 1 | 1 marks the byte as the last of its packet |
| rd_en | input | 1 | Read strobe from the host |
| rd_data | output | 8 | Byte popped by the previous read |
| rd_tag | output | 1 | Packet-end tag of the popped byte |
| evt_last | output | 1 | Pulse: tagged entry now at the head, or empty read |
| evt_above | output | 1 | Pulse: fill level rose above 16 |
| evt_ovf | output | 1 | Pulse: write attempted while full |
| evt_rd_empty | output | 1 | Pulse: read attempted while empty |

## Verification
Two pairs of functions can fall in the same cycle.

The first pair is a read and a dropped write when the FIFO is full. The bench fills the FIFO to 32 entries and then asserts both strobes together. The overflow pulse, the popped byte and the drained sequence show that the read was served and the byte was lost without harm.

The second pair is an empty read and a tagged write in the same cycle. This is judged by a single packet-end pulse together with the empty-read pulse. A zero byte must be returned, and the written byte must then read back intact.

// File: rtl/rxf_pkg.sv
package rxf_pkg;
  localparam int unsigned BYTE_W = 8;

  typedef struct packed {
    logic              tag;
    logic [BYTE_W-1:0] data;
  } rxf_ent_t;
endpackage

// File: rtl/rxf_ptr_ctrl.sv
module rxf_ptr_ctrl #(
  parameter  int unsigned DEPTH = 32,
  localparam int unsigned PTR_W = $clog2(DEPTH),
  localparam int unsigned CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_req,
  input  logic             rd_req,
  output logic             wr_ok,
  output logic             rd_ok,
  output logic [PTR_W-1:0] wptr,
  output logic [PTR_W-1:0] rptr,
  output logic [CNT_W-1:0] fill,
  output logic             head_chg_q,
  output logic             ovf_q,
  output logic             emp_rd_q
);
  function automatic logic [PTR_W-1:0] ptr_step(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  function automatic logic [CNT_W-1:0] fill_after(input logic [CNT_W-1:0] c,
                                                   input logic w, input logic r);
    return c + CNT_W'(w) - CNT_W'(r);
  endfunction

  logic             full, empty;
  logic [CNT_W-1:0] fill_nxt;

  assign full     = (fill == CNT_W'(DEPTH));
  assign empty    = (fill == '0);
  assign wr_ok    = wr_req && !full;
  assign rd_ok    = rd_req && !empty;
  assign fill_nxt = fill_after(fill, wr_ok, rd_ok);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wptr       <= '0;
      rptr       <= '0;
      fill       <= '0;
      head_chg_q <= 1'b0;
      ovf_q      <= 1'b0;
      emp_rd_q   <= 1'b0;
    end else begin
      if (wr_ok) wptr <= ptr_step(wptr);
      if (rd_ok) rptr <= ptr_step(rptr);
      fill       <= fill_nxt;
      head_chg_q <= (rd_ok && fill_nxt != '0) || (empty && wr_ok);
      ovf_q      <= wr_req && full;
      emp_rd_q   <= rd_req && empty;
    end
  end

  AST_FULL_DROP: assert property (@(posedge clk) disable iff (!rst_n)
    (full && wr_req && !rd_req) |=> (fill == CNT_W'(DEPTH)) && ovf_q && $stable(wptr)); // R3
  AST_FULL_RW: assert property (@(posedge clk) disable iff (!rst_n)
    (full && wr_req && rd_req) |=> (fill == CNT_W'(DEPTH - 1)) && ovf_q); // R8
  AST_EMPTY_RD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (empty && rd_req && !wr_req) |=> (fill == '0) && $stable(rptr) && emp_rd_q); // R6
  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    (fill == CNT_W'(DEPTH)) |=> (fill >= CNT_W'(DEPTH - 1))); // R1
endmodule

// File: rtl/rxf_store.sv
module rxf_store #(
  parameter  int unsigned DEPTH = 32,
  localparam int unsigned PTR_W = $clog2(DEPTH)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                we,
  input  logic [PTR_W-1:0]    waddr,
  input  rxf_pkg::rxf_ent_t   wdata,
  input  logic                rd_any,
  input  logic                rd_ok,
  input  logic [PTR_W-1:0]    raddr,
  output rxf_pkg::rxf_ent_t   head,
  output rxf_pkg::rxf_ent_t   rd_q
);
  rxf_pkg::rxf_ent_t mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  assign head = mem[raddr];

  always_ff @(posedge clk) begin
    if (!rst_n) rd_q <= '0;
    else if (rd_any) rd_q <= rd_ok ? mem[raddr] : '0;
  end
endmodule

// File: rtl/rxf_events.sv
module rxf_events #(
  parameter  int unsigned DEPTH   = 32,
  parameter  int unsigned HI_MARK = 16,
  localparam int unsigned CNT_W   = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [CNT_W-1:0] fill,
  input  logic             head_tag,
  input  logic             head_chg_q,
  input  logic             emp_rd_q,
  output logic             evt_above,
  output logic             evt_last
);
  function automatic logic over_mark(input logic [CNT_W-1:0] c);
    return c > CNT_W'(HI_MARK);
  endfunction

  logic above_now, above_d;
  assign above_now = over_mark(fill);

  always_ff @(posedge clk) begin
    if (!rst_n) above_d <= 1'b0;
    else        above_d <= above_now;
  end

  assign evt_above = above_now && !above_d;
  assign evt_last  = (head_chg_q && head_tag) || emp_rd_q;

  AST_ABOVE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    evt_above |=> !evt_above); // R4
  AST_ABOVE_LEVEL: assert property (@(posedge clk) disable iff (!rst_n)
    evt_above |-> (fill == CNT_W'(HI_MARK + 1))); // R4
  AST_LAST_EMPTY_READ: assert property (@(posedge clk) disable iff (!rst_n)
    emp_rd_q |-> evt_last); // R6
endmodule

// File: rtl/rx_pkt_fifo.sv
module rx_pkt_fifo #(
  parameter  int unsigned DEPTH   = 32,
  parameter  int unsigned HI_MARK = 16,
  localparam int unsigned PTR_W   = $clog2(DEPTH),
  localparam int unsigned CNT_W   = $clog2(DEPTH + 1)
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       wr_en,
  input  logic [rxf_pkg::BYTE_W-1:0] wr_data,
  input  logic                       wr_tag,
  input  logic                       rd_en,
  output logic [rxf_pkg::BYTE_W-1:0] rd_data,
  output logic                       rd_tag,
  output logic                       evt_last,
  output logic                       evt_above,
  output logic                       evt_ovf,
  output logic                       evt_rd_empty
);
  logic             wr_ok, rd_ok, head_chg_q, ovf_q, emp_rd_q;
  logic [PTR_W-1:0] wptr, rptr;
  logic [CNT_W-1:0] fill;
  rxf_pkg::rxf_ent_t wr_ent, head_ent, rd_ent;

  assign wr_ent = '{tag: wr_tag, data: wr_data};

  rxf_ptr_ctrl #(.DEPTH(DEPTH)) u_ptr (
    .clk(clk), .rst_n(rst_n), .wr_req(wr_en), .rd_req(rd_en),
    .wr_ok(wr_ok), .rd_ok(rd_ok), .wptr(wptr), .rptr(rptr), .fill(fill),
    .head_chg_q(head_chg_q), .ovf_q(ovf_q), .emp_rd_q(emp_rd_q)
  );

  rxf_store #(.DEPTH(DEPTH)) u_store (
    .clk(clk), .rst_n(rst_n), .we(wr_ok), .waddr(wptr), .wdata(wr_ent),
    .rd_any(rd_en), .rd_ok(rd_ok), .raddr(rptr), .head(head_ent), .rd_q(rd_ent)
  );

  rxf_events #(.DEPTH(DEPTH), .HI_MARK(HI_MARK)) u_evt (
    .clk(clk), .rst_n(rst_n), .fill(fill), .head_tag(head_ent.tag),
    .head_chg_q(head_chg_q), .emp_rd_q(emp_rd_q),
    .evt_above(evt_above), .evt_last(evt_last)
  );

  assign rd_data      = rd_ent.data;
  assign rd_tag       = rd_ent.tag;
  assign evt_ovf      = ovf_q;
  assign evt_rd_empty = emp_rd_q;

  AST_EMPTY_RD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    evt_rd_empty |-> (rd_data == '0) && !rd_tag); // R6
  AST_OVF_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    (evt_ovf && !$past(wr_en)) |-> 1'b0); // R3
  AST_RD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_en |=> $stable(rd_data) && $stable(rd_tag)); // R2
endmodule

// File: tb/test_rx_pkt_fifo.sv
`timescale 1ns/1ps
module test_rx_pkt_fifo;
  localparam int DEPTH = 32;
  localparam int HI    = 16;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_en = 1'b0, wr_tag = 1'b0, rd_en = 1'b0;
  logic [7:0] wr_data = '0;
  logic [7:0] rd_data;
  logic       rd_tag, evt_last, evt_above, evt_ovf, evt_rd_empty;

  always #2.5 clk = ~clk;

  rx_pkt_fifo i_rx_pkt_fifo (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data), .wr_tag(wr_tag),
    .rd_en(rd_en), .rd_data(rd_data), .rd_tag(rd_tag), .evt_last(evt_last),
    .evt_above(evt_above), .evt_ovf(evt_ovf), .evt_rd_empty(evt_rd_empty)
  );

  int n_chk = 0;
  int n_bad = 0;
  logic [8:0] mq [$];
  logic [8:0] o_rd;
  logic o_last, o_above, o_ovf, o_rde;

  task automatic chk(input string req, input string what, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // One clock cycle of stimulus; a queue model gives the expected outputs.
  task automatic cyc(input logic w, input logic [7:0] d, input logic t, input logic r);
    int n, n2;
    logic rok, wok, hc, x_ovf, x_rde, x_last, x_above;
    logic [8:0] popped;
    @(negedge clk);
    wr_en = w; wr_data = d; wr_tag = t; rd_en = r;
    n = mq.size();
    x_ovf = w && n == DEPTH;
    x_rde = r && n == 0;
    rok = r && n > 0;
    wok = w && n < DEPTH;
    popped = '0;
    if (rok) popped = mq.pop_front();
    if (wok) mq.push_back({t, d});
    n2 = mq.size();
    hc = (rok && n2 > 0) || (n == 0 && wok);
    x_last = (hc && mq[0][8]) || x_rde;
    x_above = (n2 > HI) && !(n > HI);
    @(posedge clk); #1;
    o_rd = {rd_tag, rd_data};
    o_last = evt_last; o_above = evt_above; o_ovf = evt_ovf; o_rde = evt_rd_empty;
    if (r) chk("R2", "popped entry", int'(o_rd), int'(popped));
    chk("R3", "evt_ovf", int'(o_ovf), int'(x_ovf));
    chk("R4", "evt_above", int'(o_above), int'(x_above));
    chk("R5", "evt_last", int'(o_last), int'(x_last));
    chk("R6", "evt_rd_empty", int'(o_rde), int'(x_rde));
    wr_en = 0; rd_en = 0; wr_tag = 0; wr_data = '0;
  endtask

  task automatic drain();
    while (mq.size() > 0) cyc(0, 8'h00, 0, 1);
  endtask

  task automatic t_reset();
    chk("R7", "evt_last after reset", int'(evt_last), 0);
    chk("R7", "evt_above after reset", int'(evt_above), 0);
    chk("R7", "evt_ovf after reset", int'(evt_ovf), 0);
    chk("R7", "evt_rd_empty after reset", int'(evt_rd_empty), 0);
    chk("R7", "rd output after reset", int'({rd_tag, rd_data}), 0);
    cyc(0, 8'h00, 0, 1);
    chk("R7", "empty after reset", int'(o_rde), 1);
  endtask

  task automatic t_order();
    int pulses = 0;
    cyc(1, 8'h11, 0, 0);
    cyc(1, 8'h22, 1, 0);
    cyc(1, 8'h33, 0, 0);
    cyc(1, 8'h44, 1, 0);
    cyc(1, 8'h55, 1, 0);
    for (int i = 0; i < 5; i++) begin
      cyc(0, 8'h00, 0, 1);
      if (o_last) pulses++;
    end
    // tagged heads appear after pops of 0x11, 0x33 and 0x44
    chk("R5", "packet-end pulses while draining", pulses, 3);
    chk("R2", "last byte tag", int'(o_rd[8]), 1);
    cyc(0, 8'h00, 0, 0);
    chk("R2", "rd output held while idle", int'(o_rd), 9'h155);
  endtask

  task automatic t_threshold();
    int ups = 0;
    for (int i = 0; i < 16; i++) begin
      cyc(1, 8'(i), 0, 0);
      if (o_above) ups++;
    end
    chk("R4", "no high-fill pulse up to 16", ups, 0);
    cyc(1, 8'hA0, 0, 0);
    chk("R4", "high-fill pulse at 17", int'(o_above), 1);
    cyc(1, 8'hA1, 0, 0);
    chk("R4", "no pulse at 18", int'(o_above), 0);
    cyc(0, 8'h00, 0, 1);
    cyc(0, 8'h00, 0, 1);
    cyc(1, 8'hA2, 0, 0);
    chk("R4", "pulse again after falling to 16", int'(o_above), 1);
    drain();
  endtask

  task automatic t_overflow();
    int ovfs = 0;
    for (int i = 0; i < DEPTH; i++) begin
      cyc(1, 8'(8'h40 + i), (i % 5) == 4, 0);
      if (o_ovf) ovfs++;
    end
    chk("R1", "32 writes without overflow", ovfs, 0);
    cyc(1, 8'hEE, 1, 0);
    chk("R1", "33rd write overflows", int'(o_ovf), 1);
    chk("R3", "queue depth after dropped byte", mq.size(), DEPTH);
    cyc(0, 8'h00, 0, 0);
    chk("R3", "overflow is one cycle", int'(o_ovf), 0);
    cyc(1, 8'hDD, 0, 1);
    chk("R8", "overflow with simultaneous read", int'(o_ovf), 1);
    chk("R8", "read served while full", int'(o_rd), 9'h040);
    for (int i = 0; i < DEPTH - 1; i++) cyc(0, 8'h00, 0, 1);
    chk("R8", "last drained byte is the 32nd stored", int'(o_rd[7:0]), 8'h5F);
    cyc(0, 8'h00, 0, 1);
    chk("R8", "FIFO empty after 31 pops", int'(o_rde), 1);
  endtask

  task automatic t_empty_read();
    cyc(0, 8'h00, 0, 1);
    chk("R6", "empty read data zero", int'(o_rd), 0);
    chk("R6", "empty read fires packet-end event", int'(o_last), 1);
    cyc(1, 8'h7C, 1, 1);
    chk("R6", "empty read with write: event", int'(o_rde), 1);
    chk("R6", "empty read with write: zero data", int'(o_rd), 0);
    cyc(0, 8'h00, 0, 1);
    chk("R6", "written byte intact after empty read", int'(o_rd), 9'h17C);
  endtask

  task automatic t_back_to_back_tags();
    int pulses = 0;
    cyc(1, 8'h01, 1, 0);
    if (o_last) pulses++;
    cyc(1, 8'h02, 1, 0);
    cyc(0, 8'h00, 0, 1);
    if (o_last) pulses++;
    cyc(0, 8'h00, 0, 1);
    chk("R5", "two tagged heads give two pulses", pulses, 2);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;
    @(posedge clk); #1;
    t_reset();
    t_order();
    t_threshold();
    t_overflow();
    t_empty_read();
    t_back_to_back_tags();
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    #100000;
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule